// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block catches interrupt requests from two active-low sources and holds them until they are serviced. The first source is a single dedicated interrupt pin. The second is a group of keyboard pins joined by an AND gate, so any one key pulled low makes the group input low. Each source has its own request latch, a trigger-mode bit, a mask bit and a write-one acknowledge bit. All of these sit in one 8-bit control/status register. A latch that is set and not masked drives that source's request line toward an external priority encoder.

Each pin passes through a two-flop synchronizer before the falling-edge detector. In the default mode a falling edge sets the latch. An acknowledge clears it at once, whether it comes from a software write or from the CPU's vector-fetch pulse, and the pin may still be low. In edge-plus-level mode a low level also holds the request. The latch then clears only when an acknowledge has happened and the pin is back high, and these two may occur in either order. The vector-fetch acknowledge carries a source select, so it clears only the source being serviced.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, `reg_rdata` is 8'h00 and `irq_req` is 2'b00: both latches, both mode bits and both mask bits are clear.
- R2: A falling edge on a source sets its latch. For the pin source this is `irq_pin_n` going from 1 to 0. For the key source it is the AND of all `key_pin_n` bits going from 1 to 0. A key falling while another key is already low makes no new edge.
- R3: With the mode bit at 0 (edge only), a register write with bit 4 set clears the pin latch, and one with bit 5 set clears the key latch. This happens even while the pin is still low. Writing 0 to an acknowledge bit, or acknowledging the other source, leaves a latch unchanged.
- R4: A one-cycle `vec_ack` with `vec_src` = 0 clears only the pin latch. With `vec_src` = 1 it clears only the key latch.
- R5: With the mode bit at 1 (edge plus level), a latch stays set for as long as its pin is low, even after an acknowledge.
- R6: In edge-plus-level mode, an acknowledge taken while the pin is low is remembered, and the latch clears once the pin returns high. If the pin returns high first, the latch stays set until an acknowledge arrives, and then it clears at once.
- R7: In edge-plus-level mode a low level sets the latch even without an edge. Selecting the mode while the pin is already low sets the latch.
- R8: When a source's mask bit is 1, its `irq_req` bit is 0 while its latch stays set. Clearing the mask brings the request out again.
- R9: If a falling edge and a clear of the same latch arrive in the same cycle, the latch stays set.
- R10: Register layout:
  - Bit 0 is the pin mode and bit 1 is the key mode.
  - Bit 2 is the pin mask and bit 3 is the key mask.
  - Bits 4 and 5 are the pin and key acknowledge bits, which always read 0.
  - Bits 6 and 7 are the pin and key latch status, read only.
  - Every write loads bits 0 to 3.
- R11: A reset while a pin is held low in edge-plus-level mode clears the latch and the mode bit. The latch stays clear afterwards while the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Dedicated interrupt pin, active low |
| key_pin_n | input | KEY_W | Keyboard pins, active low, AND-combined |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse |
| vec_src | input | 1 | Source being serviced: 0 pin, 1 keys |
| irq_req | output | 2 | Gated requests to priority logic: bit 0 pin, bit 1 keys |

## Verification
The bench drives falling edges on the pin and on single keys. It also drops a second key while the first is held, which shows whether the key source is treated as one combined input or as separate lines. Each acknowledge path is applied with the pin still low and with it high, in both modes. This separates an immediate clear from one that waits for the pin to rise, and an acknowledge that comes early from one that comes late. An acknowledge that lands on the same edge as a new fall tests the set-over-clear rule. A reset held while a pin stays low tests that reset leaves no false edge behind.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [KEY_W-1:0] key_pin_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             vec_ack,
  input  logic             vec_src,
  output logic [1:0]       irq_req
);

  localparam int NSRC = 2;

  logic [NSRC-1:0] raw, s1, s2, prv, fall;
  logic [NSRC-1:0] mode, mask, flag, held;
  logic [NSRC-1:0] ack, set_c, clr_c;

  assign raw = {&key_pin_n, irq_pin_n};

  // sync flops reset low so a pin held low through reset gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      prv <= '0;
    end else begin
      s1  <= raw;
      s2  <= s1;
      prv <= s2;
    end
  end

  assign fall = prv & ~s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      mask <= '0;
    end else if (reg_wr) begin
      mode <= reg_wdata[1:0];
      mask <= reg_wdata[3:2];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign ack[i]   = (reg_wr & reg_wdata[4+i]) | (vec_ack & (vec_src == 1'(i)));
    assign set_c[i] = fall[i] | (mode[i] & ~s2[i]);
    assign clr_c[i] = mode[i] ? ((ack[i] | held[i]) & s2[i]) : ack[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
        held[i] <= 1'b0;
      end else if (set_c[i]) begin
        flag[i] <= 1'b1;
        held[i] <= ~fall[i] & mode[i] & flag[i] & (held[i] | ack[i]);
      end else if (clr_c[i]) begin
        flag[i] <= 1'b0;
        held[i] <= 1'b0;
      end else begin
        held[i] <= 1'b0;
      end
    end

    a_r2_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> flag[i]);
    a_r3_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && ack[i] && !fall[i]) |=> !flag[i]);
    a_r5_level_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] && flag[i] && !s2[i]) |=> flag[i]);
    a_r6_level_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] && flag[i] && !ack[i] && !held[i]) |=> flag[i]);
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mask[i] |-> !irq_req[i]);
  end

  assign irq_req   = flag & ~mask;
  assign reg_rdata = {flag, 2'b00, mask, mode};

endmodule

// File: tb/test_ext_irq_latch.sv
`timescale 1ns/1ps
module test_ext_irq_latch;
  localparam int KEY_W = 4;

  logic clk = 0, rst_n = 0, irq_pin_n = 1, reg_wr = 0, vec_ack = 0, vec_src = 0;
  logic [KEY_W-1:0] key_pin_n = '1;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] irq_req;
  int n_chk = 0, n_bad = 0;

  ext_irq_latch #(.KEY_W(KEY_W)) i_ext_irq_latch (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .key_pin_n(key_pin_n),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_ack(vec_ack), .vec_src(vec_src), .irq_req(irq_req));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic vack(input logic src);
    @(negedge clk);
    vec_ack = 1; vec_src = src;
    @(negedge clk);
    vec_ack = 0;
  endtask

  task automatic t_reset;
    wait_cyc(4);
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 req", {6'd0, irq_req}, 8'h00);
  endtask

  task automatic t_edge_pin;
    irq_pin_n = 0; wait_cyc(4);
    chk("R2 pin latch", reg_rdata, 8'h40);
    chk("R2 pin req", {6'd0, irq_req}, 8'h01);
    wr(8'h20); chk("R3 other ack", reg_rdata, 8'h40);
    wr(8'h00); chk("R3 zero ack", reg_rdata, 8'h40);
    wr(8'h10); chk("R3 ack while low", reg_rdata, 8'h00);
    irq_pin_n = 1; wait_cyc(4);
  endtask

  task automatic t_key;
    key_pin_n[2] = 0; wait_cyc(4);
    chk("R2 key latch", reg_rdata, 8'h80);
    chk("R2 key req", {6'd0, irq_req}, 8'h02);
    wr(8'h20); chk("R3 key ack", reg_rdata, 8'h00);
    key_pin_n[0] = 0; wait_cyc(4);
    chk("R2 second key no edge", reg_rdata, 8'h00);
    key_pin_n = '1; wait_cyc(4);
  endtask

  task automatic t_vec;
    irq_pin_n = 0; key_pin_n[1] = 0; wait_cyc(4);
    chk("R4 both set", reg_rdata, 8'hC0);
    vack(1'b1); chk("R4 vec key", reg_rdata, 8'h40);
    vack(1'b0); chk("R4 vec pin", reg_rdata, 8'h00);
    irq_pin_n = 1; key_pin_n = '1; wait_cyc(4);
  endtask

  task automatic t_level;
    wr(8'h01);
    irq_pin_n = 0; wait_cyc(4);
    chk("R5 level set", reg_rdata, 8'h41);
    wr(8'h11); wait_cyc(6);
    chk("R5 held while low", reg_rdata, 8'h41);
    irq_pin_n = 1; wait_cyc(4);
    chk("R6 early ack clears on rise", reg_rdata, 8'h01);
    irq_pin_n = 0; wait_cyc(4);
    irq_pin_n = 1; wait_cyc(6);
    chk("R6 rise without ack", reg_rdata, 8'h41);
    wr(8'h11); chk("R6 late ack", reg_rdata, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_level_set;
    irq_pin_n = 0; wait_cyc(4);
    wr(8'h10); chk("R7 cleared in edge mode", reg_rdata, 8'h00);
    wr(8'h01); wait_cyc(1);
    chk("R7 low level sets", reg_rdata, 8'h41);
    irq_pin_n = 1; wait_cyc(4);
    wr(8'h11); wr(8'h00);
    chk("R7 cleanup", reg_rdata, 8'h00);
  endtask

  task automatic t_mask;
    wr(8'h04);
    irq_pin_n = 0; wait_cyc(4);
    chk("R8 masked latch kept", reg_rdata, 8'h44);
    chk("R8 masked req", {6'd0, irq_req}, 8'h00);
    wr(8'h00); chk("R8 unmasked req", {6'd0, irq_req}, 8'h01);
    wr(8'h10); irq_pin_n = 1; wait_cyc(4);
  endtask

  task automatic t_race;
    irq_pin_n = 0; wait_cyc(4);
    irq_pin_n = 1; wait_cyc(4);
    chk("R9 pre set", reg_rdata, 8'h40);
    @(negedge clk); irq_pin_n = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1; reg_wdata = 8'h10;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
    chk("R9 set wins", reg_rdata, 8'h40);
    wr(8'h10); irq_pin_n = 1; wait_cyc(4);
    chk("R9 cleanup", reg_rdata, 8'h00);
  endtask

  task automatic t_regmap;
    wr(8'h3F); chk("R10 readback", reg_rdata, 8'h0F);
    wr(8'h00); chk("R10 cleared", reg_rdata, 8'h00);
  endtask

  task automatic t_reset_low;
    wr(8'h03);
    irq_pin_n = 0; wait_cyc(4);
    chk("R11 pre", reg_rdata, 8'h43);
    @(negedge clk); rst_n = 0;
    wait_cyc(2); rst_n = 1;
    wait_cyc(6);
    chk("R11 after reset", reg_rdata, 8'h00);
    chk("R11 req", {6'd0, irq_req}, 8'h00);
    irq_pin_n = 1; wait_cyc(4);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    t_reset;
    t_edge_pin;
    t_key;
    t_vec;
    t_level;
    t_level_set;
    t_mask;
    t_race;
    t_regmap;
    t_reset_low;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule